// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a single memory burst. A one-cycle start strobe loads a starting column, a length code and an ordering bit. From the following cycle the block presents one column per beat. An advance enable moves it to the next beat, and holding that enable low freezes the burst in place, which is how a clock-suspend is modelled.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the starting column. In sequential ordering the offset inside that block counts upward and wraps. In interleaved ordering the offset is the start offset XOR the beat index. A full-page burst steps through the whole row in sequential order, wraps at the row end, and runs until a terminate input stops it. Full-page with interleaved ordering is illegal: that request raises an error flag and starts no burst.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are all low.
- R2: A legal `start_i` sets `valid_o` high on the next cycle, with `col_o` equal to the `start_col_i` value sampled with the strobe.
- R3: `len_i` encodes 2'b00 = 2 beats, 2'b01 = 4 beats, 2'b10 = 8 beats and 2'b11 = full page. With `ilv_i` = 0 and a fixed length L, the low log2(L) bits of `col_o` count up from the start offset modulo L, and the higher bits keep the start value. Length 4 from column 0x0A6 gives 0x0A6, 0x0A7, 0x0A4, 0x0A5.
- R4: With `ilv_i` = 1 and a fixed length L, the low log2(L) bits on beat n equal the start's low bits XOR n, and the higher bits are unchanged. Length 8 from 0x015 gives low offsets 5, 4, 7, 6, 1, 0, 3, 2.
- R5: A full-page burst (`len_i` = 2'b11, `ilv_i` = 0) increments the whole column by one per beat and wraps from all ones to zero. `last_o` stays low for all of it.
- R6: `last_o` is high exactly on the final beat of a fixed-length burst. Advancing from that beat drops `valid_o` on the next cycle.
- R7: While `adv_i` is low, with no start and no terminate, `col_o`, `valid_o` and `last_o` hold their values.
- R8: `term_i` during an active burst, with no start, drops `valid_o` on the next cycle.
- R9: A `start_i` during an active burst abandons it, and the next cycle shows beat 0 of the new burst. A start takes priority over `term_i` and `adv_i`.
- R10: A start with `len_i` = 2'b11 and `ilv_i` = 1 raises `err_o` for exactly the next cycle. `valid_o` is low on that cycle, and any burst in flight is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | COL_W | Starting column |
| len_i | input | 2 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| adv_i | input | 1 | Advance to the next beat; low holds |
| term_i | input | 1 | Terminate the active burst |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Previous start requested an illegal setting |

## Verification
The hardest case to reach is an illegal request that lands in the middle of a live burst, preferably while that burst is suspended. The error must abort the old burst without leaking a beat from it. The stimulus reaches this case by starting an 8-beat burst, dropping `adv_i` for several cycles, and then issuing the illegal start. A second case is the full-page wrap from the top column back to zero. The bench reaches it by starting a full-page burst three columns below the row end. A behavioural model compares every output on every cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [1:0] {
      BL_2    = 2'b00,
      BL_4    = 2'b01,
      BL_8    = 2'b10,
      BL_PAGE = 2'b11
   } blen_e;
endpackage

// File: rtl/bcs_mask_gen.sv
module bcs_mask_gen
   import bcs_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  blen_e            len,
   output logic [COL_W-1:0] mask
);
   localparam logic [COL_W-1:0] M2 = COL_W'(1);
   localparam logic [COL_W-1:0] M4 = COL_W'(3);
   localparam logic [COL_W-1:0] M8 = COL_W'(7);

   always_comb begin
      case (len)
         BL_2:    mask = M2;
         BL_4:    mask = M4;
         BL_8:    mask = M8;
         default: mask = '1;
      endcase
   end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [COL_W-1:0] beat
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) beat <= '0;
      else if (inc)      beat <= beat + 1'b1;
   end
endmodule

// File: rtl/bcs_addr_map.sv
module bcs_addr_map #(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] sum;
   assign sum = base + beat;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      assign col[i] = mask[i] ? (ilv ? (base[i] ^ beat[i]) : sum[i]) : base[i];
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [1:0]       len_i,
   input  logic             ilv_i,
   input  logic             adv_i,
   input  logic             term_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             err_o
);
   initial assert (COL_W >= 3) else $error("COL_W must cover an 8-beat block");

   blen_e            len_q;
   logic             ilv_q;
   logic [COL_W-1:0] base_q;
   logic             valid_q;
   logic             err_q;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] mask;
   logic             illegal;
   logic             at_end;
   logic             inc;

   assign illegal = start_i && (blen_e'(len_i) == BL_PAGE) && ilv_i;
   assign at_end  = valid_q && (len_q != BL_PAGE) && (beat == mask);
   assign inc     = valid_q && adv_i && !term_i && !start_i && !at_end;

   bcs_mask_gen #(.COL_W(COL_W)) u_mask (
      .len  (len_q),
      .mask (mask)
   );

   bcs_beat_ctr #(.COL_W(COL_W)) u_beat (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_i),
      .inc   (inc),
      .beat  (beat)
   );

   bcs_addr_map #(.COL_W(COL_W)) u_map (
      .base (base_q),
      .beat (beat),
      .mask (mask),
      .ilv  (ilv_q),
      .col  (col_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         len_q   <= BL_2;
         ilv_q   <= 1'b0;
         base_q  <= '0;
      end else begin
         err_q <= illegal;
         if (start_i) begin
            valid_q <= !illegal;
            len_q   <= blen_e'(len_i);
            ilv_q   <= ilv_i;
            base_q  <= start_col_i;
         end else if (valid_q && (term_i || (adv_i && at_end))) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign valid_o = valid_q;
   assign last_o  = at_end;
   assign err_o   = err_q;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [1:0]       len_i,
   input logic             ilv_i,
   input logic             adv_i,
   input logic             term_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             err_o
);
   logic bad_req;
   assign bad_req = start_i && (len_i == 2'b11) && ilv_i;

   a_r2_start_col: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !bad_req |=> valid_o && (col_o == $past(start_col_i)));

   a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && last_o && adv_i && !start_i |=> !valid_o);

   a_r6_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !adv_i && !start_i && !term_i |=>
         valid_o && $stable(col_o) && $stable(last_o));

   a_r8_term: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && term_i && !start_i |=> !valid_o);

   a_r10_err: assert property (@(posedge clk) disable iff (!rst_n)
      bad_req |=> err_o && !valid_o);

   a_r10_err_only_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_req |=> !err_o);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .len_i       (len_i),
   .ilv_i       (ilv_i),
   .adv_i       (adv_i),
   .term_i      (term_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .err_o       (err_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
   localparam int COL_W = 9;
   localparam int ROW   = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [1:0]       len_i = 2'b00;
   logic             ilv_i = 1'b0;
   logic             adv_i = 1'b0;
   logic             term_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o, last_o, err_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;
   string tag = "R1";

   // behavioural reference state
   bit m_valid = 0, m_err = 0, m_ilv = 0;
   int m_base = 0, m_beat = 0, m_len = 2;

   always #10 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_i(len_i), .ilv_i(ilv_i), .adv_i(adv_i), .term_i(term_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
   );

   function automatic int beats_of(int code);
      case (code)
         0: return 2;
         1: return 4;
         2: return 8;
         default: return 0;   // full page
      endcase
   endfunction

   function automatic int exp_col();
      int off;
      if (m_len == 0) return (m_base + m_beat) % ROW;
      off = m_base % m_len;
      if (m_ilv) return (m_base - off) + (off ^ m_beat);
      return (m_base - off) + ((off + m_beat) % m_len);
   endfunction

   function automatic bit exp_last();
      return m_valid && (m_len != 0) && (m_beat == m_len - 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_err = 0;
      end else begin
         m_err = 0;
         if (start_i) begin
            if (len_i == 2'b11 && ilv_i) begin
               m_valid = 0; m_err = 1;
            end else begin
               m_valid = 1; m_base = int'(start_col_i); m_beat = 0;
               m_len = beats_of(int'(len_i)); m_ilv = ilv_i;
            end
         end else if (m_valid && term_i) begin
            m_valid = 0;
         end else if (m_valid && adv_i) begin
            if (exp_last()) m_valid = 0;
            else m_beat = (m_beat + 1) % ROW;
         end
      end
   end

   task automatic check(string t, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(tag, "valid_o", int'(valid_o), int'(m_valid));
         check(tag, "last_o",  int'(last_o),  int'(exp_last()));
         check(tag, "err_o",   int'(err_o),   int'(m_err));
         if (m_valid) check(tag, "col_o", int'(col_o), exp_col());
      end
   end

   task automatic kick(int col, int len, bit ilv);
      @(negedge clk);
      start_i = 1; start_col_i = COL_W'(col); len_i = 2'(len); ilv_i = ilv;
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
         finish_up();
      end
   end

   initial begin
      run(3);
      @(negedge clk);
      tag = "R1";
      check("R1", "reset valid", int'(valid_o), 0);
      check("R1", "reset last",  int'(last_o),  0);
      check("R1", "reset err",   int'(err_o),   0);
      rst_n = 1;
      run(2);

      // R2 / R3: sequential length 4 from 0x0A6
      tag = "R3"; adv_i = 1;
      kick('h0A6, 1, 0);
      check("R2", "first col", int'(col_o), 'h0A6);
      run(1); check("R3", "beat1", int'(col_o), 'h0A7);
      run(1); check("R3", "beat2", int'(col_o), 'h0A4);
      run(1); check("R3", "beat3", int'(col_o), 'h0A5);
      check("R6", "last on beat3", int'(last_o), 1);
      run(1); check("R6", "valid after last", int'(valid_o), 0);

      // R4: interleaved length 8 from 0x015
      tag = "R4";
      kick('h015, 2, 1);
      check("R4", "beat0", int'(col_o), 'h015);
      run(1); check("R4", "beat1", int'(col_o), 'h014);
      run(1); check("R4", "beat2", int'(col_o), 'h017);
      run(1); check("R4", "beat3", int'(col_o), 'h016);
      run(5);

      // length 2, both orderings
      tag = "R3"; kick('h133, 0, 0); run(3);
      tag = "R4"; kick('h133, 0, 1); run(3);
      tag = "R4"; kick('h0F2, 1, 1); run(5);

      // R7: suspend a sequential length 8 burst
      tag = "R7";
      kick('h04B, 2, 0);
      adv_i = 0; run(4);
      check("R7", "held col", int'(col_o), 'h04B);
      adv_i = 1; run(2); adv_i = 0; run(3); adv_i = 1; run(8);

      // R5 / R8: full page across the row end, then terminate
      tag = "R5";
      kick('h1FD, 3, 0);
      run(3); check("R5", "wrapped col", int'(col_o), 'h000);
      check("R5", "no last", int'(last_o), 0);
      run(4);
      tag = "R8"; term_i = 1; run(1); term_i = 0;
      check("R8", "valid after term", int'(valid_o), 0);
      run(2);

      // R9: restart mid-burst, with term asserted at the same time
      tag = "R9";
      kick('h080, 2, 1);
      run(2);
      @(negedge clk);
      start_i = 1; start_col_i = 'h1C1; len_i = 2'b01; ilv_i = 0; term_i = 1;
      @(negedge clk);
      start_i = 0; term_i = 0;
      check("R9", "restart col", int'(col_o), 'h1C1);
      run(5);

      // R10: illegal request while a burst is suspended
      tag = "R10";
      kick('h020, 2, 0);
      adv_i = 0; run(3);
      kick('h055, 3, 1);
      check("R10", "err raised", int'(err_o), 1);
      check("R10", "no burst", int'(valid_o), 0);
      adv_i = 1; run(1);
      check("R10", "err one cycle", int'(err_o), 0);
      run(3);

      // full-page then term again, and a legal start right after
      tag = "R5"; kick('h010, 3, 0); run(20);
      tag = "R8"; term_i = 1; run(1); term_i = 0;
      tag = "R2"; kick('h1FF, 2, 0); run(10);

      finish_up();
   end
endmodule